// File: doc/BRIEF.md
# Core Reset and Boot-Vector Controller

This block is a small memory-mapped register target that gives software control over one processor core. Software programs two 64-bit boot vectors, one for the secure world and one for the non-secure world. It also sets the level of the core's reset line and the level of its halt line. Each vector output has a one-cycle strobe that marks the cycle in which it changes. The core uses the vector of the world it boots into.

Access is single-beat. A request carries a direction, an absolute address, a byte count and 64 bits of write data. Requests are taken only when the controller is idle. Each accepted request gets exactly one response, a fixed number of cycles later. The response carries an error flag and read data, and the read data is always zero.

The register window is 32 bytes long and starts at the parameter `BASE_ADDR`. Offsets within it are little-endian:

| Offset | Register |
|---|---|
| 0x00 | Non-secure vector, 64 bits; 0x00 is its low word and 0x04 its high word |
| 0x08 | Secure vector, 64 bits; 0x08 is its low word and 0x0C its high word |
| 0x10 | Reset level, 32 bits |
| 0x14 | Halt level, 32 bits |
| 0x18 to 0x1F | Unused |

A 4-byte write always takes its value from `req_wdata[31:0]`.

The controller runs as a three-state machine:

- IDLE: waits for a request. On `req_valid` it captures the decoded request and takes the transition ACCEPT to BUSY.
- BUSY: counts down the access latency. When the count reaches zero it takes the transition COMPLETE to RESP. The register update happens at that same edge.
- RESP: drives the response for one cycle, then takes the transition RELEASE back to IDLE.

Top module: `core_rst_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `ns_vec` and `s_vec` are zero, `core_reset`, `core_halt`, both strobes and `rsp_valid` are low.
- R2: A request taken in IDLE gets exactly one response. `rsp_valid` rises `LATENCY` clock edges after the accepting edge and stays high for one cycle. `rsp_err` is high only together with `rsp_valid`.
- R3: A read (`req_write`=0) of any address and any size is answered with `rsp_err`=0 and `rsp_rdata`=0, and changes no output.
- R4: An 8-byte write at offset 0x00 loads all 64 bits of `ns_vec`, and one at offset 0x08 loads `s_vec`. Only the written vector's strobe pulses, in the response cycle.
- R5: A 4-byte write at offset 0x00 or 0x04 replaces only the low or high half of `ns_vec` with `req_wdata[31:0]`. Offsets 0x08 and 0x0C do the same for `s_vec`. The strobe pulses.
- R6: A 4-byte write at offset 0x10 sets `core_reset` to 1 when `req_wdata[31:0]` is nonzero and to 0 when it is zero, from the response cycle on.
- R7: A 4-byte write at offset 0x14 sets `core_halt` in the same way, from `req_wdata[31:0]`.
- R8: A write whose `req_size` is neither 4 nor 8 is answered with `rsp_err`=1, and no output level or vector changes.
- R9: The following writes are answered with `rsp_err`=1 and change nothing: an 8-byte write at any offset other than 0x00 or 0x08 (this covers straddling writes), a 4-byte write at an offset that is not a multiple of 4 or that lies in 0x18 to 0x1F, and any write outside the 32-byte window.
- R10: A request presented while an access is in progress is dropped. It causes no response and no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; sampled only in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Absolute byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | DATA_W | Write data; 4-byte writes use bits 31:0 |
| rsp_valid | output | 1 | One-cycle response |
| rsp_err | output | 1 | Error response flag |
| rsp_rdata | output | DATA_W | Read data, always zero |
| ns_vec | output | DATA_W | Non-secure boot vector |
| ns_vec_upd | output | 1 | One-cycle strobe on non-secure vector update |
| s_vec | output | DATA_W | Secure boot vector |
| s_vec_upd | output | 1 | One-cycle strobe on secure vector update |
| core_reset | output | 1 | Reset level to the core |
| core_halt | output | 1 | Halt level to the core |

## Verification
The bench builds the controller with `BASE_ADDR` = 0x4000 and `LATENCY` = 3. Because the base is nonzero, an address just below the window wraps the subtraction, so the below-window rejection gets exercised. The three-cycle latency leaves BUSY cycles free, so a second request can be injected mid-access and R10 can be observed. Half-word writes carry nonzero upper data bits, which shows that only `req_wdata[31:0]` reaches the addressed half and the level registers.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int WIN_BYTES = 32;
    localparam int OFF_W     = $clog2(WIN_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_RESP
    } state_e;

    typedef enum logic [3:0] {
        TG_NONE,
        TG_NS_ALL,
        TG_NS_LO,
        TG_NS_HI,
        TG_S_ALL,
        TG_S_LO,
        TG_S_HI,
        TG_RST,
        TG_HALT
    } tgt_e;

endpackage

// File: rtl/crc_decode.sv
module crc_decode
    import crc_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic              wr,
    output tgt_e              tgt,
    output logic              err
);

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic [OFF_W-1:0]  off;

    always_comb begin
        rel    = addr - BASE_ADDR;
        in_win = (addr >= BASE_ADDR) && (rel < ADDR_W'(WIN_BYTES));
        off    = rel[OFF_W-1:0];
        tgt    = TG_NONE;
        err    = 1'b0;
        if (wr) begin
            err = 1'b1;
            if (in_win) begin
                case (size)
                    4'd8: begin
                        case (off)
                            5'h00:   begin tgt = TG_NS_ALL; err = 1'b0; end
                            5'h08:   begin tgt = TG_S_ALL;  err = 1'b0; end
                            default: ;
                        endcase
                    end
                    4'd4: begin
                        case (off)
                            5'h00:   begin tgt = TG_NS_LO; err = 1'b0; end
                            5'h04:   begin tgt = TG_NS_HI; err = 1'b0; end
                            5'h08:   begin tgt = TG_S_LO;  err = 1'b0; end
                            5'h0C:   begin tgt = TG_S_HI;  err = 1'b0; end
                            5'h10:   begin tgt = TG_RST;   err = 1'b0; end
                            5'h14:   begin tgt = TG_HALT;  err = 1'b0; end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/crc_vec_reg.sv
module crc_vec_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_full,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         upd
);

    localparam int HALF = W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            upd <= 1'b0;
        end else begin
            upd <= wr_full | wr_lo | wr_hi;
            if (wr_full) begin
                q <= wdata;
            end else if (wr_lo) begin
                q[HALF-1:0] <= wdata[HALF-1:0];
            end else if (wr_hi) begin
                q[W-1:HALF] <= wdata[HALF-1:0];
            end
        end
    end

endmodule

// File: rtl/core_rst_ctrl.sv
module core_rst_ctrl
    import crc_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                LATENCY   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] ns_vec,
    output logic              ns_vec_upd,
    output logic [DATA_W-1:0] s_vec,
    output logic              s_vec_upd,
    output logic              core_reset,
    output logic              core_halt
);

    localparam int HALF  = DATA_W / 2;
    localparam int NVEC  = 2;
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    state_e            state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    tgt_e              dec_tgt, tgt_q;
    logic              dec_err, err_q;
    logic [DATA_W-1:0] wdata_q;
    logic              fire;

    logic [NVEC-1:0]   v_full, v_lo, v_hi, v_upd;
    logic [DATA_W-1:0] v_q [NVEC];

    crc_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr (req_addr),
        .size (req_size),
        .wr   (req_write),
        .tgt  (dec_tgt),
        .err  (dec_err)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = ST_BUSY;
                    cnt_nx   = CNT_W'(LATENCY - 1);
                end
            end
            ST_BUSY: begin
                if (cnt == '0) begin
                    state_nx = ST_RESP;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign fire = (state == ST_BUSY) && (cnt == '0);

    // Outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= TG_NONE;
            err_q      <= 1'b0;
            wdata_q    <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            core_reset <= 1'b0;
            core_halt  <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                tgt_q   <= dec_tgt;
                err_q   <= dec_err;
                wdata_q <= req_wdata;
            end
            rsp_valid <= fire;
            rsp_err   <= fire & err_q;
            if (fire && tgt_q == TG_RST)  core_reset <= |wdata_q[HALF-1:0];
            if (fire && tgt_q == TG_HALT) core_halt  <= |wdata_q[HALF-1:0];
        end
    end

    assign v_full[0] = fire && (tgt_q == TG_NS_ALL);
    assign v_lo[0]   = fire && (tgt_q == TG_NS_LO);
    assign v_hi[0]   = fire && (tgt_q == TG_NS_HI);
    assign v_full[1] = fire && (tgt_q == TG_S_ALL);
    assign v_lo[1]   = fire && (tgt_q == TG_S_LO);
    assign v_hi[1]   = fire && (tgt_q == TG_S_HI);

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        crc_vec_reg #(.W(DATA_W)) u_vec (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_full (v_full[g]),
            .wr_lo   (v_lo[g]),
            .wr_hi   (v_hi[g]),
            .wdata   (wdata_q),
            .q       (v_q[g]),
            .upd     (v_upd[g])
        );
    end

    assign ns_vec     = v_q[0];
    assign ns_vec_upd = v_upd[0];
    assign s_vec      = v_q[1];
    assign s_vec_upd  = v_upd[1];
    assign rsp_rdata  = '0;

endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] ns_vec,
    input logic              ns_vec_upd,
    input logic [DATA_W-1:0] s_vec,
    input logic              s_vec_upd,
    input logic              core_reset,
    input logic              core_halt
);

    p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_err_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    p_upd_ok_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_vec_upd || s_vec_upd) |-> (rsp_valid && !rsp_err));

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ns_vec_upd, s_vec_upd}));

    p_ns_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ns_vec_upd |-> $stable(ns_vec));

    p_s_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_vec_upd |-> $stable(s_vec));

    p_reset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(core_reset));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(core_halt));

    p_err_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(core_reset) && $stable(core_halt)));

endmodule

bind core_rst_ctrl crc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .ns_vec     (ns_vec),
    .ns_vec_upd (ns_vec_upd),
    .s_vec      (s_vec),
    .s_vec_upd  (s_vec_upd),
    .core_reset (core_reset),
    .core_halt  (core_halt)
);

// File: tb/core_rst_ctrl_tb.sv
module core_rst_ctrl_tb;

    localparam int          ADDR_W = 32;
    localparam int          DATA_W = 64;
    localparam logic [31:0] BASE   = 32'h0000_4000;
    localparam int          LAT    = 3;
    localparam int          NV     = 22;

    // entry: {write, addr[31:0], size[3:0], data[63:0], kind[3:0], err}
    // kind: 0 none, 1 ns all, 2 ns lo, 3 ns hi, 4 s all, 5 s lo, 6 s hi, 7 reset, 8 halt
    localparam logic [105:0] TBL [NV] = '{
        {1'b1, 32'h4000, 4'd8, 64'h1122_3344_5566_7788, 4'd1, 1'b0},
        {1'b1, 32'h4008, 4'd8, 64'hA5A5_0000_FFFF_0001, 4'd4, 1'b0},
        {1'b1, 32'h4000, 4'd4, 64'hFFFF_FFFF_DEAD_BEEF, 4'd2, 1'b0},
        {1'b1, 32'h4004, 4'd4, 64'h0BAD_0BAD_CAFE_F00D, 4'd3, 1'b0},
        {1'b1, 32'h4008, 4'd4, 64'h7777_7777_1234_5678, 4'd5, 1'b0},
        {1'b1, 32'h400C, 4'd4, 64'h0000_0001_8765_4321, 4'd6, 1'b0},
        {1'b1, 32'h4010, 4'd4, 64'h0000_0000_0000_0001, 4'd7, 1'b0},
        {1'b1, 32'h4014, 4'd4, 64'h0000_0000_8000_0000, 4'd8, 1'b0},
        {1'b0, 32'h4000, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0},
        {1'b1, 32'h4000, 4'd2, 64'h0000_0000_0000_0055, 4'd0, 1'b1},
        {1'b1, 32'h4010, 4'd1, 64'h0000_0000_0000_0000, 4'd0, 1'b1},
        {1'b1, 32'h4008, 4'd0, 64'h1111_1111_1111_1111, 4'd0, 1'b1},
        {1'b1, 32'h4004, 4'd8, 64'h2222_2222_2222_2222, 4'd0, 1'b1},
        {1'b1, 32'h4010, 4'd8, 64'h0000_0000_0000_0000, 4'd0, 1'b1},
        {1'b1, 32'h4018, 4'd4, 64'h3333_3333_3333_3333, 4'd0, 1'b1},
        {1'b1, 32'h401C, 4'd4, 64'h4444_4444_4444_4444, 4'd0, 1'b1},
        {1'b1, 32'h4020, 4'd4, 64'h5555_5555_5555_5555, 4'd0, 1'b1},
        {1'b1, 32'h3FFC, 4'd4, 64'h6666_6666_6666_6666, 4'd0, 1'b1},
        {1'b1, 32'h4010, 4'd4, 64'hFFFF_FFFF_0000_0000, 4'd7, 1'b0},
        {1'b1, 32'h4014, 4'd4, 64'h0000_0000_0000_0000, 4'd8, 1'b0},
        {1'b0, 32'h4018, 4'd2, 64'h0000_0000_0000_0000, 4'd0, 1'b0},
        {1'b1, 32'h4010, 4'd4, 64'h0000_0000_0000_0100, 4'd7, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata, ns_vec, s_vec;
    logic              ns_vec_upd, s_vec_upd, core_reset, core_halt;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_ns = '0, m_s = '0;
    logic        m_rst = 1'b0, m_halt = 1'b0;

    always #4 clk = ~clk;

    core_rst_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE),
        .LATENCY   (LAT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .ns_vec     (ns_vec),
        .ns_vec_upd (ns_vec_upd),
        .s_vec      (s_vec),
        .s_vec_upd  (s_vec_upd),
        .core_reset (core_reset),
        .core_halt  (core_halt)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "ns_vec", ns_vec, m_ns);
        chk(req, "s_vec", s_vec, m_s);
        chk(req, "core_reset", {63'd0, core_reset}, {63'd0, m_rst});
        chk(req, "core_halt", {63'd0, core_halt}, {63'd0, m_halt});
    endtask

    // Drive one request, wait for its response, check it, then let RESP pass.
    task automatic access(input logic wr, input logic [31:0] addr, input logic [3:0] sz,
                          input logic [63:0] data, input logic [3:0] kind,
                          input logic exp_err, input string req);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_size = sz; req_wdata = data;
        @(posedge clk); #2;
        req_valid = 1'b0;
        while (!rsp_valid && n < 50) begin
            @(posedge clk); #2;
            n++;
        end
        case (kind)
            4'd1: m_ns = data;
            4'd2: m_ns[31:0] = data[31:0];
            4'd3: m_ns[63:32] = data[31:0];
            4'd4: m_s = data;
            4'd5: m_s[31:0] = data[31:0];
            4'd6: m_s[63:32] = data[31:0];
            4'd7: m_rst = |data[31:0];
            4'd8: m_halt = |data[31:0];
            default: ;
        endcase
        chk("R2", "response latency", 64'(n), 64'(LAT));
        chk(req, "rsp_err", {63'd0, rsp_err}, {63'd0, exp_err});
        chk("R3", "rsp_rdata", rsp_rdata, 64'd0);
        chk(req, "ns_vec_upd", {63'd0, ns_vec_upd},
            {63'd0, (kind >= 4'd1 && kind <= 4'd3)});
        chk(req, "s_vec_upd", {63'd0, s_vec_upd},
            {63'd0, (kind >= 4'd4 && kind <= 4'd6)});
        check_state(req);
        @(posedge clk); #2;
        chk("R2", "response one cycle", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        string tag;
        // R1: reset state, during and after reset
        repeat (3) @(posedge clk);
        #2;
        check_state("R1");
        chk("R1", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check_state("R1");
        chk("R1", "strobes after reset", {62'd0, ns_vec_upd, s_vec_upd}, 64'd0);
        chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [105:0] e;
            e = TBL[i];
            if (!e[105])                           tag = "R3";
            else if (e[0] && !(e[72:69] inside {4'd4, 4'd8})) tag = "R8";
            else if (e[0])                         tag = "R9";
            else if (e[4:1] == 4'd1 || e[4:1] == 4'd4) tag = "R4";
            else if (e[4:1] == 4'd7)               tag = "R6";
            else if (e[4:1] == 4'd8)               tag = "R7";
            else                                   tag = "R5";
            access(e[105], e[104:73], e[72:69], e[68:5], e[4:1], e[0], tag);
        end

        // R10: a request during BUSY is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = BASE;
        req_size = 4'd8; req_wdata = '0;
        @(posedge clk); #2;
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = BASE;
        req_size = 4'd8; req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(posedge clk); #2;
        req_valid = 1'b0;
        repeat (LAT - 1) begin @(posedge clk); #2; end
        chk("R10", "first response", {63'd0, rsp_valid}, 64'd1);
        chk("R10", "no update with response", {63'd0, ns_vec_upd}, 64'd0);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #2;
            chk("R10", "no extra response", {63'd0, rsp_valid}, 64'd0);
        end
        check_state("R10");

        // R1: reset during operation clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        m_ns = '0; m_s = '0; m_rst = 1'b0; m_halt = 1'b0;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check_state("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule